// File: doc/BRIEF.md
# Memory-Card SPI Command Engine

This block sits on the host side of a memory card that is driven in SPI mode. A requester hands it a 6-bit command index and a 32-bit argument. The engine builds the complete command frame, including its CRC7 check byte, and sends it one byte at a time through a byte-level SPI master. It then polls the card for the one-byte R1 status and sorts that status into a small result code. For the two commands whose replies carry an extra 32-bit word, it collects that word as well.

A second kind of request, the wake operation, sends a run of all-ones bytes with chip select released. This is the clocking a card needs after power-up. During the wake the engine raises a rate-select output so that the surrounding logic can switch the SPI clock to the slow initialisation rate. Clock generation, data-block transfers and the card start-up policy belong to the logic around this block.

The byte master is a simple handshake. The engine holds `byte_req` and `byte_tx` steady until the master pulses `byte_done` together with the received byte `byte_rx`. Each accepted request ends with exactly one `done` pulse.

Top module: `sdspi_cmd_engine`

## Requirements
- R1: A command sends exactly 7 bytes, in this order: 0xFF, then 0x40 OR the 6-bit index, then the four argument bytes with the most significant first, then the check byte.
- R2: The check byte is the 7-bit CRC over frame bytes 1 to 5, shifted left by one with bit 0 set. The CRC uses polynomial x^7+x^3+1, starts from zero and takes each byte MSB first. Index 0 with argument 0 gives 0x95; index 8 with argument 0x1AA gives 0x87.
- R3: After the frame, the engine reads up to 8 bytes while sending 0xFF, and stops at the first byte with bit 7 clear. The first byte read is never accepted, whatever its value. The `r1` output shows the accepted byte, or the last byte read if none was accepted.
- R4: `result` encodes the outcome with the first matching rule: 1 (no card) when r1 is 0xFF; 2 (CRC error) when r1 bit 3 is set; 3 (other error) when any r1 bit other than bit 0 is set; 0 (success) otherwise.
- R5: When the result is 0 and the index is 58 or 8, the engine reads 4 more bytes (sending 0xFF) and shows them on `resp` with the first byte most significant. In every other case no extra bytes are read and `resp` is 0.
- R6: `op_ready` is high at `done` only when the index is 1 or 41, the result is 0 and r1 bit 0 (idle) is clear. Otherwise it is 0.
- R7: `cs_n` is low for every byte of a command exchange, from the first frame byte to the last response byte. It is high at reset, while idle and at `done`.
- R8: A wake request (`req_wake` high) sends 18 bytes of 0xFF with `cs_n` high and `slow_rate` high on every byte. It then pulses `done` with result 0, r1 = 0x00 and `resp` = 0.
- R9: `req_ready` is high only while idle and drops in the cycle after a request is accepted. Each request yields one single-cycle `done`. `byte_req` and `byte_tx` stay unchanged until `byte_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_wake | input | 1 | Request is a wake operation rather than a command |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| byte_req | output | 1 | Byte transfer requested from the SPI master |
| byte_tx | output | 8 | Byte to shift out |
| byte_done | input | 1 | Byte transfer finished (one-cycle pulse) |
| byte_rx | input | 8 | Byte shifted in, valid with byte_done |
| cs_n | output | 1 | Card chip select, active low |
| slow_rate | output | 1 | Slow initialisation clock rate wanted |
| done | output | 1 | Request finished (one-cycle pulse) |
| result | output | 2 | Outcome code (R4) |
| r1 | output | 8 | Status byte received |
| resp | output | 32 | Extra 32-bit reply word |
| op_ready | output | 1 | Card reports start-up complete |

## Verification
The bound checker watches, on every cycle, the rules that tie signals together. These are the mapping from the reported r1 byte to the result code, the consistency of `op_ready` with r1 and the result, chip select released during a wake and at `done`, byte-request stability, and the request and done handshake pulses. Some behaviours only the bench scenarios can show, because they depend on the whole byte stream of an exchange: the exact frame bytes and CRC value, skipping the first poll byte, the 8-byte poll limit, assembly of the 32-bit reply word, and the 18-byte wake length.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

   typedef enum logic [1:0] {
      RES_OK     = 2'd0,
      RES_NOCARD = 2'd1,
      RES_CRCERR = 2'd2,
      RES_FAULT  = 2'd3
   } sdspi_result_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAKE,
      ST_FRAME,
      ST_POLL,
      ST_DECIDE,
      ST_TRAIL,
      ST_FINISH
   } sdspi_state_e;

endpackage

// File: rtl/sdspi_crc7.sv
module sdspi_crc7 #(
   parameter int CRC_W = 7,
   parameter logic [CRC_W-1:0] POLY = 7'h09
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [7:0]       din,
   output logic [CRC_W-1:0] crc
);

   if (CRC_W < 2) begin : g_bad_width
      $error("sdspi_crc7: CRC_W must be at least 2");
   end

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nxt;

   // Bitwise serial update, MSB of the byte first
   always_comb begin
      logic fb;
      crc_nxt = crc_q;
      for (int b = 7; b >= 0; b--) begin
         fb      = din[b] ^ crc_nxt[CRC_W-1];
         crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0};
         if (fb) crc_nxt = crc_nxt ^ POLY;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= '0;
      else if (clr) crc_q <= '0;
      else if (en)  crc_q <= crc_nxt;
   end

   assign crc = crc_q;

endmodule

// File: rtl/sdspi_frame_mux.sv
module sdspi_frame_mux #(
   parameter int IDX_W = 6,
   parameter int ARG_W = 32,
   parameter int CRC_W = 7,
   parameter int CNT_W = 5
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [ARG_W-1:0] arg,
   input  logic [CRC_W-1:0] crc,
   input  logic [CNT_W-1:0] sel,
   output logic [7:0]       byte_out
);

   localparam int ARG_BYTES = ARG_W / 8;
   localparam int FRAME_LEN = ARG_BYTES + 3;

   if (IDX_W != 6) begin : g_bad_idx
      $error("sdspi_frame_mux: IDX_W must be 6");
   end
   if (CRC_W != 7) begin : g_bad_crc
      $error("sdspi_frame_mux: CRC_W must be 7");
   end
   if ((ARG_W % 8) != 0 || ARG_W < 8) begin : g_bad_arg
      $error("sdspi_frame_mux: ARG_W must be a non-zero multiple of 8");
   end

   logic [7:0] frame_b [FRAME_LEN];

   assign frame_b[0]           = 8'hFF;
   assign frame_b[1]           = {2'b01, idx};
   assign frame_b[FRAME_LEN-1] = {crc, 1'b1};

   for (genvar k = 0; k < ARG_BYTES; k++) begin : g_arg
      assign frame_b[2+k] = arg[ARG_W-1-8*k -: 8];
   end

   always_comb begin
      byte_out = 8'hFF;
      for (int k = 0; k < FRAME_LEN; k++) begin
         if (sel == CNT_W'(k)) byte_out = frame_b[k];
      end
   end

endmodule

// File: rtl/sdspi_r1_classify.sv
module sdspi_r1_classify
   import sdspi_pkg::*;
(
   input  logic [7:0]    r1,
   output sdspi_result_e res
);

   always_comb begin
      if (r1 == 8'hFF)            res = RES_NOCARD;
      else if (r1[3])             res = RES_CRCERR;
      else if (r1[7:1] != 7'd0)   res = RES_FAULT;
      else                        res = RES_OK;
   end

endmodule

// File: rtl/sdspi_cmd_engine.sv
module sdspi_cmd_engine
   import sdspi_pkg::*;
#(
   parameter int IDX_W       = 6,
   parameter int ARG_W       = 32,
   parameter int POLL_MAX    = 8,
   parameter int WAKE_BYTES  = 18,
   parameter int TRAIL_BYTES = 4,
   parameter int IDX_OCR     = 58,
   parameter int IDX_IFCOND  = 8,
   parameter int IDX_OPC_A   = 1,
   parameter int IDX_OPC_B   = 41
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_wake,
   input  logic [IDX_W-1:0]         req_index,
   input  logic [ARG_W-1:0]         req_arg,
   output logic                     byte_req,
   output logic [7:0]               byte_tx,
   input  logic                     byte_done,
   input  logic [7:0]               byte_rx,
   output logic                     cs_n,
   output logic                     slow_rate,
   output logic                     done,
   output logic [1:0]               result,
   output logic [7:0]               r1,
   output logic [TRAIL_BYTES*8-1:0] resp,
   output logic                     op_ready
);

   localparam int ARG_BYTES = ARG_W / 8;
   localparam int FRAME_LEN = ARG_BYTES + 3;
   localparam int RESP_W    = TRAIL_BYTES * 8;
   localparam int CRC_W     = 7;
   localparam int MAX_A     = (FRAME_LEN > POLL_MAX) ? FRAME_LEN : POLL_MAX;
   localparam int MAX_B     = (WAKE_BYTES > TRAIL_BYTES) ? WAKE_BYTES : TRAIL_BYTES;
   localparam int CNT_MAX   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W     = $clog2(CNT_MAX + 1);

   localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);
   localparam logic [CNT_W-1:0] POLL_LAST  = CNT_W'(POLL_MAX - 1);
   localparam logic [CNT_W-1:0] WAKE_LAST  = CNT_W'(WAKE_BYTES - 1);
   localparam logic [CNT_W-1:0] TRAIL_LAST = CNT_W'(TRAIL_BYTES - 1);
   localparam logic [CNT_W-1:0] CRC_FIRST  = CNT_W'(1);
   localparam logic [CNT_W-1:0] CRC_LAST   = CNT_W'(FRAME_LEN - 2);

   if (POLL_MAX < 2) begin : g_bad_poll
      $error("sdspi_cmd_engine: POLL_MAX must be at least 2");
   end
   if (WAKE_BYTES < 1) begin : g_bad_wake
      $error("sdspi_cmd_engine: WAKE_BYTES must be at least 1");
   end
   if (TRAIL_BYTES < 2) begin : g_bad_trail
      $error("sdspi_cmd_engine: TRAIL_BYTES must be at least 2");
   end
   if (IDX_OCR >= (1 << IDX_W) || IDX_IFCOND >= (1 << IDX_W) ||
       IDX_OPC_A >= (1 << IDX_W) || IDX_OPC_B >= (1 << IDX_W)) begin : g_bad_idx
      $error("sdspi_cmd_engine: command index parameter out of range");
   end

   sdspi_state_e     state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] idx_q;
   logic [ARG_W-1:0] arg_q;
   logic             long_q;
   logic             opc_q;
   logic [7:0]       r1_q;
   logic [RESP_W-1:0] resp_q;
   sdspi_result_e    res_q;
   logic             opr_q;

   logic [CRC_W-1:0] crc_val;
   logic [7:0]       frame_byte;
   sdspi_result_e    cls;
   logic             accept;
   logic             crc_en;
   logic             req_long;
   logic             req_opc;

   assign accept   = (state_q == ST_IDLE) && req_valid;
   assign crc_en   = (state_q == ST_FRAME) && byte_done &&
                     (cnt_q >= CRC_FIRST) && (cnt_q <= CRC_LAST);
   assign req_long = (req_index == IDX_W'(IDX_OCR)) || (req_index == IDX_W'(IDX_IFCOND));
   assign req_opc  = (req_index == IDX_W'(IDX_OPC_A)) || (req_index == IDX_W'(IDX_OPC_B));

   sdspi_crc7 #(
      .CRC_W (CRC_W),
      .POLY  (7'h09)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .en    (crc_en),
      .din   (byte_tx),
      .crc   (crc_val)
   );

   sdspi_frame_mux #(
      .IDX_W (IDX_W),
      .ARG_W (ARG_W),
      .CRC_W (CRC_W),
      .CNT_W (CNT_W)
   ) u_frame (
      .idx      (idx_q),
      .arg      (arg_q),
      .crc      (crc_val),
      .sel      (cnt_q),
      .byte_out (frame_byte)
   );

   sdspi_r1_classify u_cls (
      .r1  (r1_q),
      .res (cls)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         arg_q   <= '0;
         long_q  <= 1'b0;
         opc_q   <= 1'b0;
         r1_q    <= 8'hFF;
         resp_q  <= '0;
         res_q   <= RES_OK;
         opr_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  cnt_q  <= '0;
                  resp_q <= '0;
                  opr_q  <= 1'b0;
                  if (req_wake) begin
                     state_q <= ST_WAKE;
                  end else begin
                     idx_q   <= req_index;
                     arg_q   <= req_arg;
                     long_q  <= req_long;
                     opc_q   <= req_opc;
                     r1_q    <= 8'hFF;
                     state_q <= ST_FRAME;
                  end
               end
            end
            ST_WAKE: begin
               if (byte_done) begin
                  if (cnt_q == WAKE_LAST) begin
                     res_q   <= RES_OK;
                     r1_q    <= 8'h00;
                     state_q <= ST_FINISH;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_FRAME: begin
               if (byte_done) begin
                  if (cnt_q == FRAME_LAST) begin
                     cnt_q   <= '0;
                     state_q <= ST_POLL;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_POLL: begin
               if (byte_done) begin
                  r1_q <= byte_rx;
                  if ((cnt_q != '0 && !byte_rx[7]) || cnt_q == POLL_LAST) begin
                     state_q <= ST_DECIDE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_DECIDE: begin
               res_q   <= cls;
               opr_q   <= opc_q && (cls == RES_OK) && !r1_q[0];
               cnt_q   <= '0;
               state_q <= (cls == RES_OK && long_q) ? ST_TRAIL : ST_FINISH;
            end
            ST_TRAIL: begin
               if (byte_done) begin
                  resp_q <= {resp_q[RESP_W-9:0], byte_rx};
                  if (cnt_q == TRAIL_LAST) state_q <= ST_FINISH;
                  else                     cnt_q   <= cnt_q + 1'b1;
               end
            end
            ST_FINISH: begin
               state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign byte_req  = (state_q == ST_WAKE) || (state_q == ST_FRAME) ||
                      (state_q == ST_POLL) || (state_q == ST_TRAIL);
   assign byte_tx   = (state_q == ST_FRAME) ? frame_byte : 8'hFF;
   assign cs_n      = !((state_q == ST_FRAME) || (state_q == ST_POLL) ||
                        (state_q == ST_DECIDE) || (state_q == ST_TRAIL));
   assign slow_rate = (state_q == ST_WAKE);
   assign done      = (state_q == ST_FINISH);
   assign result    = res_q;
   assign r1        = r1_q;
   assign resp      = resp_q;
   assign op_ready  = opr_q;

endmodule

// File: rtl/sdspi_cmd_engine_chk.sv
module sdspi_cmd_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       byte_req,
   input logic       byte_done,
   input logic [7:0] byte_tx,
   input logic       cs_n,
   input logic       slow_rate,
   input logic       done,
   input logic [1:0] result,
   input logic [7:0] r1,
   input logic       op_ready
);

   // R8
   wake_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slow_rate |-> cs_n);

   // R4
   nocard_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((r1 == 8'hFF) == (result == 2'd1)));

   // R4
   crcerr_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && r1 != 8'hFF && r1[3]) |-> (result == 2'd2));

   // R4
   ok_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == 2'd0) |-> ((r1 & 8'hFE) == 8'h00));

   // R6
   opready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_ready) |-> (!r1[0] && result == 2'd0));

   // R9
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_req && !byte_done) |=> (byte_req && $stable(byte_tx)));

   // R9
   accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R7
   done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cs_n);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind sdspi_cmd_engine sdspi_cmd_engine_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .byte_req  (byte_req),
   .byte_done (byte_done),
   .byte_tx   (byte_tx),
   .cs_n      (cs_n),
   .slow_rate (slow_rate),
   .done      (done),
   .result    (result),
   .r1        (r1),
   .op_ready  (op_ready)
);

// File: tb/sdspi_cmd_engine_tb.sv
module sdspi_cmd_engine_tb;

   logic        clk;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic        req_wake;
   logic [5:0]  req_index;
   logic [31:0] req_arg;
   logic        byte_req;
   logic [7:0]  byte_tx;
   logic        byte_done;
   logic [7:0]  byte_rx;
   logic        cs_n;
   logic        slow_rate;
   logic        done;
   logic [1:0]  result;
   logic [7:0]  r1;
   logic [31:0] resp;
   logic        op_ready;

   int checks;
   int errors;
   int cycles;

   // byte master model state and logs
   logic [7:0] script [16];
   logic [7:0] tx_log [64];
   logic       cs_log [64];
   logic       slow_log [64];
   int         nbytes;
   int         m_pos;
   int         m_cnt;
   logic       m_busy;

   sdspi_cmd_engine u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_wake  (req_wake),
      .req_index (req_index),
      .req_arg   (req_arg),
      .byte_req  (byte_req),
      .byte_tx   (byte_tx),
      .byte_done (byte_done),
      .byte_rx   (byte_rx),
      .cs_n      (cs_n),
      .slow_rate (slow_rate),
      .done      (done),
      .result    (result),
      .r1        (r1),
      .resp      (resp),
      .op_ready  (op_ready)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   // Byte-level SPI master model, acting on the falling edge
   always @(negedge clk) begin
      if (!rst_n) begin
         byte_done = 1'b0;
         byte_rx   = 8'hFF;
         m_busy    = 1'b0;
         m_cnt     = 0;
      end else if (byte_done) begin
         byte_done = 1'b0;
      end else if (m_busy) begin
         if (m_cnt == 0) begin
            m_busy = 1'b0;
            if (m_pos >= 7 && m_pos - 7 < 16 && !slow_log[m_pos])
               byte_rx = script[m_pos-7];
            else
               byte_rx = 8'hFF;
            byte_done = 1'b1;
         end else begin
            m_cnt = m_cnt - 1;
         end
      end else if (byte_req) begin
         m_pos = nbytes;
         if (nbytes < 64) begin
            tx_log[nbytes]   = byte_tx;
            cs_log[nbytes]   = cs_n;
            slow_log[nbytes] = slow_rate;
         end
         nbytes = nbytes + 1;
         m_busy = 1'b1;
         m_cnt  = 1 + (nbytes % 3);
      end
   end

   initial begin
      cycles = 0;
      forever begin
         @(posedge clk);
         cycles = cycles + 1;
         if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [6:0] crc7_of(input logic [39:0] v);
      logic [6:0] c;
      logic fb;
      c = 7'd0;
      for (int i = 39; i >= 0; i--) begin
         fb = v[i] ^ c[6];
         c  = {c[5:0], 1'b0};
         if (fb) c = c ^ 7'h09;
      end
      return c;
   endfunction

   function automatic logic [1:0] class_of(input logic [7:0] b);
      if (b == 8'hFF)          return 2'd1;
      if (b[3])                return 2'd2;
      if ((b & 8'hFE) != 8'h0) return 2'd3;
      return 2'd0;
   endfunction

   task automatic clear_script();
      for (int i = 0; i < 16; i++) script[i] = 8'hFF;
   endtask

   task automatic wait_done(output bit ok);
      int n;
      n  = 0;
      ok = 1'b1;
      while (!done) begin
         @(negedge clk);
         n = n + 1;
         if (n > 3000) begin
            ok = 1'b0;
            chk(1'b0, "R9 done timeout", 64'(n), 64'd0);
            return;
         end
      end
   endtask

   task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg);
      logic [7:0]  f [7];
      logic [7:0]  r1e;
      logic [1:0]  rese;
      logic [31:0] respe;
      logic        long_cmd;
      logic        opre;
      int          polls;
      int          total;
      bit          ok;
      bit          cs_ok;

      f[0] = 8'hFF;
      f[1] = 8'h40 | {2'b00, idx};
      f[2] = arg[31:24];
      f[3] = arg[23:16];
      f[4] = arg[15:8];
      f[5] = arg[7:0];
      f[6] = {crc7_of({f[1], f[2], f[3], f[4], f[5]}), 1'b1};

      polls = 8;
      r1e   = script[7];
      for (int i = 0; i < 8; i++) begin
         if (i > 0 && !script[i][7]) begin
            polls = i + 1;
            r1e   = script[i];
            break;
         end
      end
      rese     = class_of(r1e);
      long_cmd = (idx == 6'd58) || (idx == 6'd8);
      respe    = 32'd0;
      if (rese == 2'd0 && long_cmd)
         respe = {script[polls], script[polls+1], script[polls+2], script[polls+3]};
      opre  = ((idx == 6'd1) || (idx == 6'd41)) && rese == 2'd0 && !r1e[0];
      total = 7 + polls + ((rese == 2'd0 && long_cmd) ? 4 : 0);

      @(negedge clk);
      chk(req_ready === 1'b1, "R9 ready before request", 64'(req_ready), 64'd1);
      nbytes    = 0;
      req_valid = 1'b1;
      req_wake  = 1'b0;
      req_index = idx;
      req_arg   = arg;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready === 1'b0, "R9 ready drops after accept", 64'(req_ready), 64'd0);
      wait_done(ok);
      if (!ok) return;

      for (int i = 0; i < 6; i++)
         chk(tx_log[i] === f[i], "R1 frame byte", 64'(tx_log[i]), 64'(f[i]));
      chk(tx_log[6] === f[6], "R2 check byte", 64'(tx_log[6]), 64'(f[6]));
      chk(nbytes == total, "R3/R5 byte count", 64'(nbytes), 64'(total));
      cs_ok = 1'b1;
      for (int i = 0; i < nbytes && i < 64; i++) begin
         if (cs_log[i] !== 1'b0) cs_ok = 1'b0;
         if (i >= 7 && tx_log[i] !== 8'hFF) cs_ok = 1'b0;
      end
      chk(cs_ok, "R7 cs low and 0xFF fill on response bytes", 64'(cs_ok), 64'd1);
      chk(cs_n === 1'b1, "R7 cs released at done", 64'(cs_n), 64'd1);
      chk(r1 === r1e, "R3 r1 byte", 64'(r1), 64'(r1e));
      chk(result === rese, "R4 result code", 64'(result), 64'(rese));
      chk(resp === respe, "R5 reply word", 64'(resp), 64'(respe));
      chk(op_ready === opre, "R6 op_ready", 64'(op_ready), 64'(opre));
      @(negedge clk);
      chk(done === 1'b0, "R9 done single cycle", 64'(done), 64'd0);
   endtask

   task automatic run_wake();
      bit ok;
      bit all_ok;
      @(negedge clk);
      nbytes    = 0;
      req_valid = 1'b1;
      req_wake  = 1'b1;
      req_index = 6'h3F;
      req_arg   = 32'hDEADBEEF;
      @(negedge clk);
      req_valid = 1'b0;
      req_wake  = 1'b0;
      wait_done(ok);
      if (!ok) return;
      chk(nbytes == 18, "R8 wake byte count", 64'(nbytes), 64'd18);
      all_ok = 1'b1;
      for (int i = 0; i < nbytes && i < 64; i++)
         if (tx_log[i] !== 8'hFF || cs_log[i] !== 1'b1 || slow_log[i] !== 1'b1)
            all_ok = 1'b0;
      chk(all_ok, "R8 wake bytes 0xFF with cs high and slow rate", 64'(all_ok), 64'd1);
      chk(result === 2'd0 && r1 === 8'h00 && resp === 32'd0, "R8 wake completion",
          {30'd0, result, 24'd0, r1}, 64'd0);
      @(negedge clk);
      chk(slow_rate === 1'b0, "R8 slow rate dropped", 64'(slow_rate), 64'd0);
   endtask

   initial begin
      logic [5:0] ridx;
      checks    = 0;
      errors    = 0;
      nbytes    = 0;
      m_pos     = 0;
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_wake  = 1'b0;
      req_index = 6'd0;
      req_arg   = 32'd0;
      for (int i = 0; i < 64; i++) begin
         tx_log[i]   = 8'h00;
         cs_log[i]   = 1'b0;
         slow_log[i] = 1'b0;
      end
      clear_script();
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      chk(req_ready === 1'b1 && cs_n === 1'b1 && byte_req === 1'b0 && done === 1'b0,
          "R7/R9 reset state", {60'd0, req_ready, cs_n, byte_req, done}, 64'b1100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R8 wake sequence
      run_wake();

      // R2 known check byte 0x95, reply idle
      clear_script(); script[1] = 8'h01;
      run_cmd(6'd0, 32'd0);
      chk(tx_log[6] === 8'h95, "R2 literal 0x95", 64'(tx_log[6]), 64'h95);

      // R5 interface condition with reply word, R2 literal 0x87
      clear_script(); script[2] = 8'h01;
      script[3] = 8'h00; script[4] = 8'h00; script[5] = 8'h01; script[6] = 8'hAA;
      run_cmd(6'd8, 32'h0000_01AA);
      chk(tx_log[6] === 8'h87, "R2 literal 0x87", 64'(tx_log[6]), 64'h87);

      // R3 first byte clear but ignored, then nothing: no card
      clear_script(); script[0] = 8'h00;
      run_cmd(6'd17, 32'h1234_5678);

      // R3 response on the last permitted poll
      clear_script(); script[7] = 8'h00;
      run_cmd(6'd16, 32'h0000_0200);

      // R3 no valid byte, last byte not 0xFF: generic error
      clear_script(); for (int i = 0; i < 8; i++) script[i] = 8'h80 | 8'(i);
      run_cmd(6'd13, 32'd0);

      // R6 ready and still idle
      clear_script(); script[1] = 8'h00;
      run_cmd(6'd41, 32'h4000_0000);
      clear_script(); script[3] = 8'h01;
      run_cmd(6'd1, 32'd0);

      // R5 read-OCR rejected: no extra bytes
      clear_script(); script[1] = 8'h05;
      run_cmd(6'd58, 32'd0);
      // R4 CRC error outranks other bits
      clear_script(); script[2] = 8'h4C;
      run_cmd(6'd24, 32'hFFFF_FFFF);
      // R5 read-OCR success
      clear_script(); script[1] = 8'h00;
      script[2] = 8'hC0; script[3] = 8'hFF; script[4] = 8'h80; script[5] = 8'h00;
      run_cmd(6'd58, 32'd0);

      // Constrained random commands
      for (int t = 0; t < 40; t++) begin
         int mode;
         int pos;
         clear_script();
         mode = $urandom_range(0, 4);
         pos  = $urandom_range(1, 7);
         if ($urandom_range(0, 1) == 1) script[0] = 8'($urandom) & 8'h7F;
         case (mode)
            0: ;
            1: script[pos] = 8'($urandom) & 8'h7F;
            2: script[pos] = 8'($urandom_range(0, 1));
            3: script[pos] = (8'($urandom) & 8'h7F) | 8'h08;
            default: for (int i = 1; i < 8; i++) script[i] = 8'h80 | 8'($urandom);
         endcase
         for (int i = pos + 1; i < 16; i++)
            if (mode != 4) script[i] = 8'($urandom);
         case ($urandom_range(0, 5))
            0: ridx = 6'd58;
            1: ridx = 6'd8;
            2: ridx = 6'd1;
            3: ridx = 6'd41;
            default: ridx = 6'($urandom);
         endcase
         run_cmd(ridx, $urandom);
      end

      // R8 wake again after commands
      run_wake();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule